// File: doc/BRIEF.md
# Multichannel ADC Scan Controller with Sample FIFO

This block is the digital front end of a 16-input analog acquisition channel. A host programs it through a small register window: the channel to convert (or the top of the scan range), a 3-bit gain code, the trigger source, and the interrupt source. Each trigger starts one conversion. The trigger can be a write to a strobe register, a tick from an external pacer counter, or a rising edge on an external trigger pin. The converter itself sits outside the block. The block asks it for a conversion with a one-cycle start pulse that carries the channel and gain. It then takes the result back on a valid strobe.

Results go into a 1024-entry first-in first-out store, and the host drains that store by reading the data register. A status register gives a converter-busy bit, a data-available bit, and two flags that read 0 when active: one for half full and one for full. The host empties the store by setting and then clearing a bit in the interrupt control register. The interrupt line asserts either on every stored sample or when the store reaches half full. It stays asserted until the host writes the interrupt clear register.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the status register (offset 0x08) reads 0x0060, the interrupt line is low and no conversion is requested.
- R2: Writing offset 0x08 stores the low 3 data bits as the gain code. The gain code reads back in status bits 2:0 and drives `conv_gain`.
- R3: With auto-scan off (trigger control bit 0 = 0), every conversion uses the channel held in the channel register at offset 0x06.
- R4: With auto-scan on, successive conversions use channels 0, 1, … up to the channel register value and then wrap to 0. The sequence restarts at 0 whenever trigger control (offset 0x0A) is written.
- R5: A write of any value to offset 0x0E starts one conversion when trigger control bits 1 and 2 are both 0. The same write has no effect when either bit is 1.
- R6: With trigger control bit 1 set, each `pacer_tick` pulse starts one conversion. With bit 1 clear and bit 2 set, each rising edge of `ext_trig` starts exactly one conversion, however long the level is held.
- R7: Reading offset 0x00 returns the oldest stored sample and removes it. Status bit 4 reads 1 while at least one sample is stored.
- R8: Status bit 5 reads 0 while 512 or more samples are stored and 1 otherwise.
- R9: When 1024 samples are stored, status bit 6 reads 0 and any further results are discarded. Bit 6 stays 0 until the store is cleared, even after samples are read.
- R10: Setting interrupt control (offset 0x0C) bit 2 does not affect the stored data. A later write that clears bit 2 empties the store and releases the full flag.
- R11: With interrupt control bit 0 = 0, every stored sample raises `irq`. A write to offset 0x48 lowers `irq`.
- R12: With interrupt control bit 0 = 1, `irq` rises when the stored count reaches 512 and not before.
- R13: Status bit 7 reads 1 from the start pulse until the result is returned. Triggers that arrive while busy are ignored.
- R14: Writing 0 to trigger control makes the strobe register the only trigger and turns auto-scan off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (pops the store at offset 0x00) |
| bus_addr | input | 7 | Host register offset |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from `bus_addr` |
| pacer_tick | input | 1 | One-cycle tick from the external pacer counter |
| ext_trig | input | 1 | External trigger level |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the requested conversion |
| conv_gain | output | 3 | Gain code for the converter |
| sample_valid | input | 1 | Converter result strobe |
| sample_data | input | 16 | Converter result |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench walks the auto-scan sequence through a wrap. A sequencer that fails to return to 0, or that skips the top channel, would store the wrong channel numbers. It fills the store past 1024 entries and reads every entry. A design that overwrote old data instead of dropping new data would return the wrong sequence numbers. A design with a non-sticky full flag would release bit 6 after the first read. The clear test sets the enable bit without clearing it and checks that no data is lost, so a design that clears on the set edge fails. The half-full interrupt is checked at 511 and at 512 entries, and a second trigger is sent while busy, so off-by-one thresholds and double conversions both show up.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFF_FIFO  = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_CHAN  = 7'h06;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_TRIG  = 7'h0A;
    localparam logic [ADDR_W-1:0] OFF_INTC  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFF_SWTRG = 7'h0E;
    localparam logic [ADDR_W-1:0] OFF_ICLR  = 7'h48;

    // Bit positions in the interrupt control register
    localparam int INTC_SRC_BIT = 0;
    localparam int INTC_CLR_BIT = 2;

    // Status register bit positions
    localparam int STAT_BUSY  = 7;
    localparam int STAT_FULLN = 6;
    localparam int STAT_HALFN = 5;
    localparam int STAT_AVAIL = 4;

    // Trigger control, bit 0 is the least significant member
    typedef struct packed {
        logic event_md;
        logic post_md;
        logic pre_md;
        logic ext_sel;
        logic tmr_sel;
        logic auto_scan;
    } trig_ctrl_t;
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int GAIN_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    input  logic              busy,
    input  logic              fifo_full,
    input  logic              fifo_half,
    input  logic              fifo_avail,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              push_evt,
    input  logic              half_rise,
    output logic [CHAN_W-1:0] last_chan,
    output logic [GAIN_W-1:0] gain,
    output logic              auto_scan,
    output logic              conv_trig,
    output logic              trig_wr,
    output logic              fifo_pop,
    output logic              fifo_clr,
    output logic              irq
);
    localparam int INTC_W = 4;

    typedef struct packed {
        logic [CHAN_W-1:0] last;
        logic [GAIN_W-1:0] gain;
        trig_ctrl_t        trig;
        logic [INTC_W-1:0] intc;
        logic              ext_q;
        logic              irq;
    } regs_t;

    regs_t s_q, s_d;

    logic wr_chan, wr_stat, wr_trig, wr_intc, wr_swtrg, wr_iclr;
    logic irq_set;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

    always_comb begin
        wr_chan  = bus_wr && (bus_addr == OFF_CHAN);
        wr_stat  = bus_wr && (bus_addr == OFF_STAT);
        wr_trig  = bus_wr && (bus_addr == OFF_TRIG);
        wr_intc  = bus_wr && (bus_addr == OFF_INTC);
        wr_swtrg = bus_wr && (bus_addr == OFF_SWTRG);
        wr_iclr  = bus_wr && (bus_addr == OFF_ICLR);

        s_d       = s_q;
        s_d.ext_q = ext_trig;
        if (wr_chan) s_d.last = bus_wdata[CHAN_W-1:0];
        if (wr_stat) s_d.gain = bus_wdata[GAIN_W-1:0];
        if (wr_trig) s_d.trig = trig_ctrl_t'(bus_wdata[5:0]);
        if (wr_intc) s_d.intc = bus_wdata[INTC_W-1:0];

        // Clear fires on the falling edge of the stored enable bit
        fifo_clr = wr_intc && s_q.intc[INTC_CLR_BIT] && !bus_wdata[INTC_CLR_BIT];
        trig_wr  = wr_trig;
        fifo_pop = bus_rd && (bus_addr == OFF_FIFO);

        if (s_q.trig.tmr_sel)      conv_trig = pacer_tick;
        else if (s_q.trig.ext_sel) conv_trig = ext_trig && !s_q.ext_q;
        else                       conv_trig = wr_swtrg;

        irq_set = s_q.intc[INTC_SRC_BIT] ? half_rise : push_evt;
        if (wr_iclr) s_d.irq = 1'b0;
        if (irq_set) s_d.irq = 1'b1;

        bus_rdata = '0;
        case (bus_addr)
            OFF_FIFO: bus_rdata = fifo_rdata;
            OFF_CHAN: bus_rdata[CHAN_W-1:0] = s_q.last;
            OFF_STAT: begin
                bus_rdata[STAT_BUSY]  = busy;
                bus_rdata[STAT_FULLN] = !fifo_full;
                bus_rdata[STAT_HALFN] = !fifo_half;
                bus_rdata[STAT_AVAIL] = fifo_avail;
                bus_rdata[GAIN_W-1:0] = s_q.gain;
            end
            OFF_TRIG: bus_rdata[5:0] = s_q.trig;
            OFF_INTC: bus_rdata[INTC_W-1:0] = s_q.intc;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign last_chan = s_q.last;
    assign gain      = s_q.gain;
    assign auto_scan = s_q.trig.auto_scan;
    assign irq       = s_q.irq;

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iclr && !push_evt && !half_rise) |=> !irq); // R11
    AST_EXT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.trig.ext_sel && !s_q.trig.tmr_sel && $past(ext_trig) && ext_trig) |-> !conv_trig); // R6
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_trig,
    input  logic              auto_scan,
    input  logic [CHAN_W-1:0] last_chan,
    input  logic              trig_wr,
    input  logic              sample_valid,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              busy,
    output logic              push_evt
);
    typedef struct packed {
        logic              busy;
        logic              start;
        logic [CHAN_W-1:0] chan;
        logic [CHAN_W-1:0] idx;
    } seq_t;

    seq_t s_q, s_d;
    logic [CHAN_W-1:0] pick;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        pick      = (s_q.idx > last_chan) ? '0 : s_q.idx;

        if (s_q.busy && sample_valid) s_d.busy = 1'b0;

        if (conv_trig && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.start = 1'b1;
            if (auto_scan) begin
                s_d.chan = pick;
                s_d.idx  = (pick == last_chan) ? '0 : pick + 1'b1;
            end else begin
                s_d.chan = last_chan;
            end
        end

        if (trig_wr) s_d.idx = '0;

        push_evt = s_q.busy && sample_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.start;
    assign conv_chan  = s_q.chan;
    assign busy       = s_q.busy;

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !conv_start); // R13
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample_valid) |=> busy); // R13
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(auto_scan)) |-> (conv_chan <= $past(last_chan))); // R4
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic              clr,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              half,
    output logic              avail,
    output logic              half_rise
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CNT_W-1:0] cnt;
        logic             full;
    } fifo_t;

    fifo_t s_q, s_d;
    logic  push_ok, pop_ok;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        push_ok = push && (s_q.cnt < DEPTH_C);
        pop_ok  = pop && (s_q.cnt != '0);
        s_d     = s_q;
        if (push_ok) s_d.wptr = s_q.wptr + 1'b1;
        if (pop_ok)  s_d.rptr = s_q.rptr + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (s_d.cnt == DEPTH_C) s_d.full = 1'b1;
        if (clr) s_d = '0;
        half_rise = !clr && (s_q.cnt < HALF_C) && (s_d.cnt >= HALF_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[s_q.wptr] <= wdata;
    end

    assign rdata = mem[s_q.rptr];
    assign full  = s_q.full;
    assign half  = s_q.cnt >= HALF_C;
    assign avail = s_q.cnt != '0;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= DEPTH_C); // R9
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!avail && !full)); // R10
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int GAIN_W = 3,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [GAIN_W-1:0] conv_gain,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    output logic              irq
);
    logic              busy, push_evt, half_rise;
    logic              f_full, f_half, f_avail;
    logic [DATA_W-1:0] f_rdata;
    logic [CHAN_W-1:0] last_chan;
    logic              auto_scan, conv_trig, trig_wr, f_pop, f_clr;

    adc_scan_regs #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .busy(busy), .fifo_full(f_full), .fifo_half(f_half), .fifo_avail(f_avail),
        .fifo_rdata(f_rdata), .push_evt(push_evt), .half_rise(half_rise),
        .last_chan(last_chan), .gain(conv_gain), .auto_scan(auto_scan),
        .conv_trig(conv_trig), .trig_wr(trig_wr), .fifo_pop(f_pop),
        .fifo_clr(f_clr), .irq(irq)
    );

    adc_scan_seq #(.CHAN_W(CHAN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .conv_trig(conv_trig), .auto_scan(auto_scan), .last_chan(last_chan),
        .trig_wr(trig_wr), .sample_valid(sample_valid),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .busy(busy), .push_evt(push_evt)
    );

    adc_scan_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_evt), .wdata(sample_data), .pop(f_pop), .clr(f_clr),
        .rdata(f_rdata), .full(f_full), .half(f_half), .avail(f_avail),
        .half_rise(half_rise)
    );
endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic [2:0]  conv_gain;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_data = '0;
    logic        irq;

    int checks = 0, fails = 0, produced = 0, conv_delay = 2;

    always #2 clk = ~clk;

    adc_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
        .sample_valid(sample_valid), .sample_data(sample_data), .irq(irq)
    );

    // Converter model: result = {sequence number, channel}
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                logic [3:0] ch;
                ch = conv_chan;
                repeat (conv_delay) @(negedge clk);
                sample_data  = {produced[11:0], ch};
                sample_valid = 1'b1;
                @(negedge clk);
                sample_valid = 1'b0;
                produced++;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_prod(input int target);
        wait (produced >= target);
        @(negedge clk);
    endtask

    task automatic soft_conv();
        int t;
        t = produced;
        wr(7'h0E, 16'h1234);
        wait_prod(t + 1);
    endtask

    task automatic tick_conv();
        int t;
        t = produced;
        pacer_tick = 1'b1;
        @(negedge clk);
        pacer_tick = 1'b0;
        wait_prod(t + 1);
    endtask

    task automatic flush(input logic [15:0] src);
        wr(7'h0C, 16'h0004 | src);
        wr(7'h0C, src);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(7'h08, v);
        chk("R1 status", v, 16'h0060);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 start", {15'd0, conv_start}, 16'd0);
    endtask

    task automatic t_gain();
        logic [15:0] v;
        wr(7'h08, 16'h0005);
        rd(7'h08, v);
        chk("R2 readback", v & 16'h0007, 16'h0005);
        chk("R2 pin", {13'd0, conv_gain}, 16'h0005);
        wr(7'h08, 16'hFFFA);
        rd(7'h08, v);
        chk("R2 low bits only", v & 16'h0007, 16'h0002);
    endtask

    task automatic t_single();
        logic [15:0] v;
        flush(0);
        wr(7'h06, 16'h0009);
        soft_conv();
        soft_conv();
        rd(7'h08, v);
        chk("R7 avail", (v >> 4) & 16'h1, 16'h1);
        rd(7'h00, v);
        chk("R3 chan a", v & 16'hF, 16'h9);
        rd(7'h00, v);
        chk("R3 chan b", v & 16'hF, 16'h9);
        rd(7'h08, v);
        chk("R7 empty", (v >> 4) & 16'h1, 16'h0);
    endtask

    task automatic t_autoscan();
        logic [15:0] v, prev;
        int bad;
        logic [3:0] exp_ch [5] = '{0, 1, 2, 0, 1};
        flush(0);
        wr(7'h06, 16'h0002);
        wr(7'h0A, 16'h0001);
        for (int k = 0; k < 5; k++) soft_conv();
        bad = 0;
        prev = '0;
        for (int k = 0; k < 5; k++) begin
            rd(7'h00, v);
            if (v[3:0] !== exp_ch[k]) bad++;
            if (k > 0 && v[15:4] !== prev[15:4] + 12'd1) bad++;
            prev = v;
        end
        chk("R4 scan wrap and R7 order", 16'(bad), 16'd0);
        // Rewriting trigger control restarts the sequence at channel 0
        soft_conv();
        wr(7'h0A, 16'h0001);
        soft_conv();
        rd(7'h00, v);
        rd(7'h00, v);
        chk("R4 restart", v & 16'hF, 16'h0);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        int t;
        flush(0);
        wr(7'h0A, 16'h0000);
        conv_delay = 20;
        t = produced;
        wr(7'h0E, 16'h0000);
        repeat (3) @(negedge clk);
        rd(7'h08, v);
        chk("R13 busy set", (v >> 7) & 16'h1, 16'h1);
        wr(7'h0E, 16'h0000);
        wait_prod(t + 1);
        repeat (30) @(negedge clk);
        chk("R13 second trigger ignored", 16'(produced - t), 16'd1);
        rd(7'h08, v);
        chk("R13 busy clear", (v >> 7) & 16'h1, 16'h0);
        rd(7'h00, v);
        rd(7'h08, v);
        chk("R13 one sample stored", (v >> 4) & 16'h1, 16'h0);
        conv_delay = 2;
    endtask

    task automatic t_sources();
        logic [15:0] v;
        int t;
        flush(0);
        wr(7'h06, 16'h0004);
        wr(7'h0A, 16'h0002);
        t = produced;
        wr(7'h0E, 16'h0000);
        repeat (15) @(negedge clk);
        chk("R5 strobe ignored in pacer mode", 16'(produced - t), 16'd0);
        tick_conv();
        chk("R6 pacer tick", 16'(produced - t), 16'd1);
        rd(7'h00, v);
        chk("R6 pacer chan", v & 16'hF, 16'h4);
        wr(7'h0A, 16'h0004);
        t = produced;
        ext_trig = 1'b1;
        repeat (20) @(negedge clk);
        ext_trig = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 ext edge once", 16'(produced - t), 16'd1);
        wr(7'h0E, 16'h0000);
        repeat (15) @(negedge clk);
        chk("R5 strobe ignored in ext mode", 16'(produced - t), 16'd1);
    endtask

    task automatic t_zero();
        logic [15:0] v;
        int t;
        flush(0);
        wr(7'h06, 16'h0007);
        wr(7'h0A, 16'h0003);
        wr(7'h0A, 16'h0000);
        t = produced;
        soft_conv();
        chk("R14 strobe works", 16'(produced - t), 16'd1);
        rd(7'h00, v);
        chk("R14 auto-scan off", v & 16'hF, 16'h7);
    endtask

    task automatic t_irq_eoc();
        flush(0);
        wr(7'h48, 16'h0000);
        chk("R11 idle low", {15'd0, irq}, 16'd0);
        soft_conv();
        chk("R11 raised", {15'd0, irq}, 16'd1);
        wr(7'h48, 16'h0000);
        chk("R11 cleared", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_fill();
        logic [15:0] v;
        int base, bad;
        flush(16'h0001);
        wr(7'h48, 16'h0000);
        wr(7'h0A, 16'h0002);
        base = produced;
        for (int k = 0; k < 511; k++) tick_conv();
        rd(7'h08, v);
        chk("R8 below half", (v >> 5) & 16'h1, 16'h1);
        chk("R12 no irq at 511", {15'd0, irq}, 16'd0);
        tick_conv();
        rd(7'h08, v);
        chk("R8 half", (v >> 5) & 16'h1, 16'h0);
        chk("R12 irq at 512", {15'd0, irq}, 16'd1);
        for (int k = 0; k < 512 + 3; k++) tick_conv();
        rd(7'h08, v);
        chk("R9 full", (v >> 6) & 16'h1, 16'h0);
        bad = 0;
        for (int k = 0; k < 1020; k++) begin
            rd(7'h00, v);
            if (v[15:4] !== 12'(base + k)) bad++;
        end
        chk("R9 oldest kept", 16'(bad), 16'd0);
        rd(7'h08, v);
        chk("R9 full sticky", (v >> 6) & 16'h1, 16'h0);
        for (int k = 0; k < 4; k++) rd(7'h00, v);
        chk("R9 newest dropped", {4'd0, v[15:4]}, {4'd0, 12'(base + 1023)});
        rd(7'h08, v);
        chk("R9 empty after 1024", (v >> 4) & 16'h1, 16'h0);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        flush(0);
        wr(7'h0A, 16'h0000);
        soft_conv();
        soft_conv();
        wr(7'h0C, 16'h0004);
        rd(7'h08, v);
        chk("R10 set alone keeps data", (v >> 4) & 16'h1, 16'h1);
        wr(7'h0C, 16'h0000);
        rd(7'h08, v);
        chk("R10 cleared", v & 16'h0070, 16'h0060);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gain();
        t_single();
        t_autoscan();
        t_busy();
        t_sources();
        t_zero();
        t_irq_eoc();
        t_fill();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule